// File: doc/BRIEF.md
# Next Program Counter Control Unit

This block holds the program counter of a 16-bit, word-addressed processor with eight general registers. It decides the next PC once per instruction. The next PC can come from plain sequential flow, a conditional branch tested against a one-hot sign register, a jump through a register (a return is the same jump through register 7), a subroutine call in PC-relative or register form, or a system-call trap. Calls and traps share one link path. That path writes the incremented PC into register 7.

A trap needs a second, indirect access. In its first cycle the block reads a word from a 256-entry vector table at the bottom of memory. In its second cycle it loads the PC from the returned word. While it waits for that word it raises `busy`, so that fetch holds. The register file, the arithmetic datapath and the service routines live outside the block. The block names the register it wants to read on `base_sel` and takes the value back on `base_data` in the same cycle.

Top module: `nextpc_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `pc` is 0x3000, `busy` is 0, and `pc_inc` equals `pc`+1 modulo 2^16.
- R2: An instruction is accepted when `instr_valid` is 1 and `busy` is 0. If its opcode (`instr[15:12]`) is not 0, 4, 12 or 15, the PC becomes `pc`+1 modulo 2^16 (0xFFFF wraps to 0x0000), and `redirect`, `link_we` and `vec_rd_en` stay 0.
- R3: Opcode 0 is a branch. It is taken when `instr[11:9]` AND `cond_nzp` is nonzero, where `cond_nzp` is one-hot with bit 2 negative, bit 1 zero and bit 0 positive. A taken branch sets the PC to `pc`+1 plus `instr[8:0]` sign-extended, modulo 2^16, and raises `redirect` in its accept cycle.
- R4: A branch that is not taken sets the PC to `pc`+1 and leaves `redirect` at 0.
- R5: Opcode 12 loads the PC from `base_data`. `base_sel` always shows `instr[8:6]`. The jump raises `redirect` and does not request a link write.
- R6: Opcode 4 (call) raises `link_we` in its accept cycle, with `link_idx`=7 and `link_data`=`pc`+1. If `instr[11]` is 1, the PC becomes `pc`+1 plus `instr[10:0]` sign-extended, modulo 2^16.
- R7: A call with `instr[11]`=0 loads the PC from `base_data` as presented in the accept cycle. With base register 7 this is the value from before the link write.
- R8: Opcode 15 (trap), in its accept cycle, raises `link_we` with `link_data`=`pc`+1, and raises `vec_rd_en` with `vec_addr` equal to `instr[7:0]` zero-extended. In the next cycle `busy` is 1 and `pc` is unchanged.
- R9: In the cycle that `busy` is 1, `redirect` is 1 and `instr_valid` is ignored. On the following edge the PC loads `vec_data`, and `busy` returns to 0.
- R10: While `instr_valid` is 0 and `busy` is 0, `pc` holds, and `link_we`, `vec_rd_en` and `redirect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | A fetched instruction is present on `instr` |
| instr | input | 16 | Fetched instruction word |
| cond_nzp | input | 3 | One-hot sign of last result: bit 2 negative, bit 1 zero, bit 0 positive |
| base_sel | output | 3 | Register index to read for jumps and register calls (`instr[8:6]`) |
| base_data | input | 16 | Contents of the register named by `base_sel`, same cycle |
| link_we | output | 1 | Write request for the link register |
| link_idx | output | 3 | Link register index, always 7 |
| link_data | output | 16 | Return address to write (`pc`+1) |
| vec_rd_en | output | 1 | Read request to the trap vector table |
| vec_addr | output | 16 | Vector table word address, 0x0000 to 0x00FF |
| vec_data | input | 16 | Vector word, valid in the cycle after `vec_rd_en` |
| pc | output | 16 | Current program counter |
| pc_inc | output | 16 | `pc`+1 modulo 2^16 |
| redirect | output | 1 | The PC is being loaded with a non-sequential target |
| busy | output | 1 | Trap vector wait; fetch must hold |

## Verification
Two situations are hard to reach from the ports. The first is the trap wait cycle: the bench can only reach it by issuing a real trap. It then drives a stray valid branch during that cycle, and presents the vector word only after the issue edge, so a design that samples `vec_data` early, or accepts the stray branch, loads a wrong PC. The second is the wrap of relative targets across 0xFFFF/0x0000. The block has no way to load the PC directly, so the bench first places it at 0xFFFF, 0x0000 or 0x3000 with a register jump. It then sweeps every branch mask against every sign, using offsets at both ends of their range, and sweeps all 256 trap vectors.

// File: rtl/nextpc_pkg.sv
`timescale 1ns/1ps
// Shared opcode values, FSM state and decoded-control struct for the
// next-PC unit. Assumes a 16-bit instruction with the opcode in [15:12].
package nextpc_pkg;
    localparam logic [3:0] OPC_BRANCH = 4'h0;
    localparam logic [3:0] OPC_CALL   = 4'h4;
    localparam logic [3:0] OPC_JUMP   = 4'hC;
    localparam logic [3:0] OPC_TRAP   = 4'hF;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_VEC = 1'b1
    } npc_state_e;

    typedef struct packed {
        logic       is_branch;
        logic       is_call;
        logic       is_jump;
        logic       is_trap;
        logic       call_rel;
        logic [2:0] nzp_mask;
    } npc_ctl_t;
endpackage

// File: rtl/nextpc_decode.sv
`timescale 1ns/1ps
// Splits an instruction word into control class flags, sign-extended
// PC-relative offsets, the base register index and the trap vector address.
// Assumes field positions of a 16-bit encoding; XLEN must be at least 16.
module nextpc_decode
    import nextpc_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int RIDX_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic [XLEN-1:0]   instr,
    output npc_ctl_t          ctl,
    output logic [XLEN-1:0]   off_branch,
    output logic [XLEN-1:0]   off_call,
    output logic [RIDX_W-1:0] base_idx,
    output logic [XLEN-1:0]   vec_word_addr
);
    localparam int BR_OFF_W   = 9;
    localparam int CALL_OFF_W = 11;

    logic [3:0] opcode;

    // Classify the opcode and pull out the condition mask and call form.
    always_comb begin
        opcode        = instr[15:12];
        ctl.is_branch = (opcode == OPC_BRANCH);
        ctl.is_call   = (opcode == OPC_CALL);
        ctl.is_jump   = (opcode == OPC_JUMP);
        ctl.is_trap   = (opcode == OPC_TRAP);
        ctl.call_rel  = instr[11];
        ctl.nzp_mask  = instr[11:9];
    end

    // Sign-extend the relative offsets and zero-extend the vector index.
    always_comb begin
        off_branch    = {{(XLEN-BR_OFF_W){instr[BR_OFF_W-1]}}, instr[BR_OFF_W-1:0]};
        off_call      = {{(XLEN-CALL_OFF_W){instr[CALL_OFF_W-1]}}, instr[CALL_OFF_W-1:0]};
        base_idx      = instr[6 +: RIDX_W];
        vec_word_addr = {{(XLEN-VEC_W){1'b0}}, instr[VEC_W-1:0]};
    end
endmodule

// File: rtl/nextpc_target.sv
`timescale 1ns/1ps
// Chooses the next PC for a single-cycle control transfer (everything
// except the trap, whose target arrives from memory a cycle later).
// Assumes cond_nzp is one-hot and pc_inc is already PC+1.
module nextpc_target
    import nextpc_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  npc_ctl_t        ctl,
    input  logic [2:0]      cond_nzp,
    input  logic [XLEN-1:0] pc_inc,
    input  logic [XLEN-1:0] off_branch,
    input  logic [XLEN-1:0] off_call,
    input  logic [XLEN-1:0] base_data,
    output logic [XLEN-1:0] next_pc,
    output logic            take
);
    logic br_hit;

    // Branch test: any overlap between the mask and the sign register.
    always_comb br_hit = ctl.is_branch && (|(ctl.nzp_mask & cond_nzp));

    // Target mux; all sums wrap at XLEN bits.
    always_comb begin
        next_pc = pc_inc;
        take    = 1'b0;
        if (br_hit) begin
            next_pc = pc_inc + off_branch;
            take    = 1'b1;
        end else if (ctl.is_jump) begin
            next_pc = base_data;
            take    = 1'b1;
        end else if (ctl.is_call) begin
            next_pc = ctl.call_rel ? (pc_inc + off_call) : base_data;
            take    = 1'b1;
        end
    end
endmodule

// File: rtl/nextpc_ctrl.sv
`timescale 1ns/1ps
// Program counter register and trap sequencer. Accepts one instruction per
// cycle when not busy, links calls and traps to register LINK_REG, and
// fetches trap targets from a low-memory vector table with one cycle of
// read latency. Assumes base_data is the register value before any
// same-cycle link write (write-at-edge register file).
module nextpc_ctrl
    import nextpc_pkg::*;
#(
    parameter int              XLEN     = 16,
    parameter int              RIDX_W   = 3,
    parameter int              VEC_W    = 8,
    parameter int              LINK_REG = 7,
    parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [XLEN-1:0]   instr,
    input  logic [2:0]        cond_nzp,
    output logic [RIDX_W-1:0] base_sel,
    input  logic [XLEN-1:0]   base_data,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data,
    output logic              vec_rd_en,
    output logic [XLEN-1:0]   vec_addr,
    input  logic [XLEN-1:0]   vec_data,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   pc_inc,
    output logic              redirect,
    output logic              busy
);
    npc_state_e      st_q;
    logic [XLEN-1:0] pc_q;
    npc_ctl_t        ctl;
    logic [XLEN-1:0] off_br, off_cl, vec_wa, tgt;
    logic            take, accept;

    nextpc_decode #(.XLEN(XLEN), .RIDX_W(RIDX_W), .VEC_W(VEC_W)) dec_i (
        .instr        (instr),
        .ctl          (ctl),
        .off_branch   (off_br),
        .off_call     (off_cl),
        .base_idx     (base_sel),
        .vec_word_addr(vec_wa)
    );

    nextpc_target #(.XLEN(XLEN)) tgt_i (
        .ctl       (ctl),
        .cond_nzp  (cond_nzp),
        .pc_inc    (pc_inc),
        .off_branch(off_br),
        .off_call  (off_cl),
        .base_data (base_data),
        .next_pc   (tgt),
        .take      (take)
    );

    // Accept gating and the outward requests derived from it.
    always_comb begin
        pc        = pc_q;
        pc_inc    = pc_q + {{(XLEN-1){1'b0}}, 1'b1};
        busy      = (st_q == ST_VEC);
        accept    = instr_valid && !busy;
        link_we   = accept && (ctl.is_call || ctl.is_trap);
        link_idx  = RIDX_W'(LINK_REG);
        link_data = pc_inc;
        vec_rd_en = accept && ctl.is_trap;
        vec_addr  = vec_wa;
        redirect  = (accept && take) || busy;
    end

    // PC register and two-state trap sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
            st_q <= ST_RUN;
        end else begin
            unique case (st_q)
                ST_RUN: begin
                    if (accept) begin
                        if (ctl.is_trap) st_q <= ST_VEC;
                        else             pc_q <= tgt;
                    end
                end
                ST_VEC: begin
                    pc_q <= vec_data;
                    st_q <= ST_RUN;
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/nextpc_ctrl_chk.sv
`timescale 1ns/1ps
// Temporal checks on the next-PC unit's ports, attached by bind.
module nextpc_ctrl_chk #(
    parameter int              XLEN     = 16,
    parameter logic [XLEN-1:0] RESET_PC = 16'h3000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [XLEN-1:0] instr,
    input logic            link_we,
    input logic [XLEN-1:0] link_data,
    input logic            vec_rd_en,
    input logic [XLEN-1:0] vec_data,
    input logic [XLEN-1:0] pc,
    input logic            redirect,
    input logic            busy
);
    logic [XLEN-1:0] pc_plus;
    logic            acc, plain, trap_go;

    always_comb begin
        pc_plus = pc + 1'b1;
        acc     = instr_valid && !busy;
        trap_go = acc && (instr[15:12] == 4'hF);
        plain   = acc && !(instr[15:12] inside {4'h0, 4'h4, 4'hC, 4'hF});
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk) $rose(rst_n) |-> (pc == RESET_PC && !busy));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plain |=> pc == $past(pc_plus));

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == pc_plus && !busy));

    // R8
    trap_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_go |=> (busy && pc == $past(pc)));

    // R9
    trap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && pc == $past(vec_data)));

    // R9
    busy_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (redirect && !link_we && !vec_rd_en));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !busy) |=> $stable(pc));
endmodule

bind nextpc_ctrl nextpc_ctrl_chk #(.XLEN(XLEN), .RESET_PC(RESET_PC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_valid(instr_valid),
    .instr      (instr),
    .link_we    (link_we),
    .link_data  (link_data),
    .vec_rd_en  (vec_rd_en),
    .vec_data   (vec_data),
    .pc         (pc),
    .redirect   (redirect),
    .busy       (busy)
);

// File: tb/nextpc_ctrl_tb_top.sv
`timescale 1ns/1ps
module nextpc_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0;
    logic [2:0]  cond_nzp = 3'b010;
    logic [2:0]  base_sel;
    logic [15:0] base_data = 16'h0;
    logic        link_we;
    logic [2:0]  link_idx;
    logic [15:0] link_data;
    logic        vec_rd_en;
    logic [15:0] vec_addr;
    logic [15:0] vec_data = 16'h0;
    logic [15:0] pc, pc_inc;
    logic        redirect, busy;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    nextpc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .cond_nzp(cond_nzp), .base_sel(base_sel), .base_data(base_data),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
        .vec_rd_en(vec_rd_en), .vec_addr(vec_addr), .vec_data(vec_data),
        .pc(pc), .pc_inc(pc_inc), .redirect(redirect), .busy(busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input int v, input int bits);
        int r;
        r = v & ((1 << bits) - 1);
        if (r >= (1 << (bits - 1))) r = r - (1 << bits);
        return 16'(r);
    endfunction

    // Drive at the falling edge, settle, leave sampling to caller.
    task automatic drive(input logic v, input logic [15:0] ins, input logic [2:0] nzp, input logic [15:0] bd);
        @(negedge clk);
        instr_valid = v; instr = ins; cond_nzp = nzp; base_data = bd;
        #1;
    endtask

    task automatic finish_edge();
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    // Place the PC with a register jump through register 3.
    task automatic set_pc(input logic [15:0] v);
        drive(1'b1, 16'hC0C0, 3'b010, v);
        finish_edge();
        check("R5 jump places pc", pc, v);
    endtask

    initial begin
        logic [15:0] p0, exp;
        logic [15:0] pcs [3];
        int brofs [5];
        int clofs [5];
        pcs[0] = 16'h3000; pcs[1] = 16'hFFFF; pcs[2] = 16'h0000;
        brofs[0] = 0; brofs[1] = 1; brofs[2] = 255; brofs[3] = 256; brofs[4] = 511;
        clofs[0] = 0; clofs[1] = 1; clofs[2] = 1023; clofs[3] = 1024; clofs[4] = 2047;

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 pc in reset", pc, 16'h3000);
        check("R1 busy in reset", {15'h0, busy}, 16'h0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 pc after reset", pc, 16'h3000);
        check("R1 pc_inc", pc_inc, 16'h3001);

        // R10 idle holds
        drive(1'b0, 16'h1234, 3'b001, 16'h0);
        check("R10 no link when idle", {15'h0, link_we | vec_rd_en | redirect}, 16'h0);
        finish_edge();
        check("R10 pc holds", pc, 16'h3000);

        // R2 every non-control opcode, including wrap
        for (int op = 0; op < 16; op++) begin
            if (op == 0 || op == 4 || op == 12 || op == 15) continue;
            for (int k = 0; k < 2; k++) begin
                set_pc(pcs[k]);
                drive(1'b1, {4'(op), 12'hFFF}, 3'b100, 16'hAAAA);
                check("R2 no redirect/link/vec", {13'h0, redirect, link_we, vec_rd_en}, 16'h0);
                finish_edge();
                check("R2 sequential pc", pc, pcs[k] + 16'd1);
            end
        end

        // R3/R4 branch sweep: all masks, all signs, edge offsets, wrapping pcs
        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 3; s++)
                for (int o = 0; o < 5; o++)
                    for (int k = 0; k < 3; k++) begin
                        logic [2:0] nzp;
                        bit hit;
                        nzp = 3'(1 << s);
                        hit = (m & (1 << s)) != 0;
                        set_pc(pcs[k]);
                        p0 = pcs[k];
                        drive(1'b1, {4'h0, 3'(m), 9'(brofs[o])}, nzp, 16'h0);
                        exp = hit ? (p0 + 16'd1 + sx(brofs[o], 9)) : (p0 + 16'd1);
                        if (hit) check("R3 taken redirect", {15'h0, redirect}, 16'h1);
                        else     check("R4 untaken no redirect", {15'h0, redirect}, 16'h0);
                        finish_edge();
                        if (hit) check("R3 taken target", pc, exp);
                        else     check("R4 untaken pc+1", pc, exp);
                    end

        // R5 jump through each base register
        for (int r = 0; r < 8; r++) begin
            drive(1'b1, {4'hC, 3'b000, 3'(r), 6'h00}, 3'b010, 16'h1000 + 16'(r * 16'h111));
            check("R5 base_sel", {13'h0, base_sel}, 16'(r));
            check("R5 no link", {15'h0, link_we}, 16'h0);
            check("R5 redirect", {15'h0, redirect}, 16'h1);
            finish_edge();
            check("R5 jump target", pc, 16'h1000 + 16'(r * 16'h111));
        end

        // R6 relative calls
        for (int o = 0; o < 5; o++)
            for (int k = 0; k < 3; k++) begin
                set_pc(pcs[k]);
                p0 = pcs[k];
                drive(1'b1, {4'h4, 1'b1, 11'(clofs[o])}, 3'b001, 16'h0);
                check("R6 link_we", {15'h0, link_we}, 16'h1);
                check("R6 link_idx", {13'h0, link_idx}, 16'h7);
                check("R6 link_data", link_data, p0 + 16'd1);
                finish_edge();
                check("R6 call target", pc, p0 + 16'd1 + sx(clofs[o], 11));
            end

        // R7 register call through register 7 uses presented (old) value
        set_pc(16'h4444);
        drive(1'b1, {4'h4, 1'b0, 2'b00, 3'd7, 6'h00}, 3'b001, 16'h5150);
        check("R7 base_sel r7", {13'h0, base_sel}, 16'h7);
        check("R7 link_data", link_data, 16'h4445);
        finish_edge();
        check("R7 register call target", pc, 16'h5150);

        // R8/R9 every trap vector, with a stray instruction during the wait
        for (int v = 0; v < 256; v++) begin
            logic [15:0] vw;
            vw = 16'((v * 257) ^ 16'h5A5A);
            p0 = pc;
            drive(1'b1, {4'hF, 4'h0, 8'(v)}, 3'b010, 16'h0);
            check("R8 link_data", link_data, p0 + 16'd1);
            check("R8 vec request", {15'h0, vec_rd_en & link_we}, 16'h1);
            check("R8 vec_addr", vec_addr, 16'(v));
            @(posedge clk); #1;
            check("R8 busy", {15'h0, busy}, 16'h1);
            check("R8 pc unchanged", pc, p0);
            instr = 16'h0E05; cond_nzp = 3'b111; instr_valid = 1'b1;
            vec_data = vw;
            #1;
            check("R9 redirect while busy", {15'h0, redirect}, 16'h1);
            check("R9 no link while busy", {15'h0, link_we | vec_rd_en}, 16'h0);
            finish_edge();
            check("R9 pc from vector", pc, vw);
            check("R9 busy cleared", {15'h0, busy}, 16'h0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule